// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a timer peripheral with a parameterised number of independent 16-bit channels. The default is two channels. All channels run from one functional clock. Software reaches them through a simple synchronous register bus.

Each channel counts upward, one step per tick. It takes its tick from its own power-of-two divider of the functional clock. When the count equals the programmed limit, the channel does two things. It sets a pending flag. It then either wraps to zero and keeps running (periodic mode) or stops and drops its own enable (single-shot mode).

A single interrupt line is the OR of every channel's pending flag gated by that channel's interrupt enable. Typical uses are a periodic tick or a programmed single delay on one channel, and a free-running up-counter on another channel used as a time base.

Top module: `pscl_timer`

## Requirements
- R1: Each channel ch has four 16-bit registers at byte addresses 0x80+0x80*ch (control), 0x84+0x80*ch (status), 0x88+0x80*ch (limit) and 0x8C+0x80*ch (count). All of them read 0 after reset. The count register is read-only, so bus writes to it are ignored.
- R2: Control keeps bit 8 (interrupt enable), bit 5 (run), bit 4 (single-shot) and bits [3:0] (divider code). All other bits read back as 0.
- R3: With divider code n in 0..8, a running channel advances its count once every 2^n functional clock cycles. The count is 1 after the first 2^n cycles that follow the write setting run.
- R4: Divider codes 9 to 15 divide by 256, the same as code 8. The code field reads back exactly as it was written.
- R5: In periodic mode (bit 4 = 0), the tick that finds count equal to the limit sets status bit 0 and returns the count to 0. Counting continues without software action.
- R6: With a limit of 0xFFFF in periodic mode the channel is a free-running counter that wraps from 0xFFFF to 0.
- R7: In single-shot mode, the tick that finds count equal to the limit does three things: it sets status bit 0, clears the run bit (read back as 0 in control), and returns the count to 0. The count then stays at 0.
- R8: A control write that changes run from 0 to 1 clears both the count and the divider. The next interval is then measured against the limit value current at that time.
- R9: Writing 1 to status bit 0 clears the pending flag. Writing 0 leaves it unchanged.
- R10: irq is 1 exactly when some channel has its pending flag set together with its interrupt-enable bit.
- R11: Read data appears on bus_rdata one clock after the read is presented and holds its value until the next read.
- R12: Channels run independently, each with its own divider code, limit and mode.
- R13: While run is 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock shared by all channels |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Combined interrupt |

## Verification
The bench times count reads against the enable edge for several divider codes. A divider that is off by one cycle, or that ignores the clamp for codes 9 to 15, therefore shows up as a wrong count value.

Three mode corner cases are covered:
- The single-shot stop is read back through the control register. A design that fails to drop run keeps counting.
- Reprogramming the limit between a disable and a re-enable must restart the count from 0. A design that fails to clear on the enable edge resumes from the frozen value instead.
- A long free-running run with the limit at 0xFFFF, alongside a second channel on a different divider, exposes a wrap that stops at the top or channels that influence each other.

The interrupt line is checked for masking, and the write-1-to-clear flag is checked against a write of 0.

// File: rtl/pscl_timer_pkg.sv
package pscl_timer_pkg;
  localparam int DATA_W   = 16;
  localparam int CODE_W   = 4;
  localparam int DIV_W    = 8;
  localparam int MAX_CODE = 8;
  localparam int BIT_IE   = 8;
  localparam int BIT_RUN  = 5;
  localparam int BIT_ONE  = 4;

  typedef struct packed {
    logic              irq_en;
    logic              run;
    logic              single;
    logic [CODE_W-1:0] code;
  } ctl_t;

  function automatic ctl_t ctl_decode(input logic [DATA_W-1:0] w);
    ctl_t c;
    c.irq_en = w[BIT_IE];
    c.run    = w[BIT_RUN];
    c.single = w[BIT_ONE];
    c.code   = w[CODE_W-1:0];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctl_encode(input ctl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_IE]       = c.irq_en;
    w[BIT_RUN]      = c.run;
    w[BIT_ONE]      = c.single;
    w[CODE_W-1:0]   = c.code;
    return w;
  endfunction

  function automatic logic [CODE_W-1:0] code_clamp(input logic [CODE_W-1:0] code);
    return (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
  endfunction

  function automatic logic [DIV_W-1:0] div_mask(input logic [CODE_W-1:0] code);
    logic [DIV_W:0] full;
    full = ((DIV_W+1)'(1) << code_clamp(code)) - (DIV_W+1)'(1);
    return full[DIV_W-1:0];
  endfunction
endpackage

// File: rtl/pscl_div.sv
module pscl_div
  import pscl_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = div_mask(code);
  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (run)     div_q <= div_q + DIV_W'(1);
  end

  assert_div1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && code == '0) |-> tick);
  assert_tick_gated_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);
endmodule

// File: rtl/pscl_chan.sv
module pscl_chan
  import pscl_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_stat,
  input  logic              wr_lim,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_rd,
  output logic [DATA_W-1:0] stat_rd,
  output logic [DATA_W-1:0] lim_rd,
  output logic [DATA_W-1:0] cnt_rd,
  output logic              irq_o
);
  ctl_t              ctl_q;
  ctl_t              ctl_new;
  logic [DATA_W-1:0] lim_q;
  logic [DATA_W-1:0] cnt_q;
  logic              pend_q;
  logic              tick;
  logic              at_lim;
  logic              expire;
  logic              run_rise;
  logic              clr_req;

  assign ctl_new  = ctl_decode(wdata);
  assign run_rise = wr_ctl && ctl_new.run && !ctl_q.run;
  assign at_lim   = (cnt_q == lim_q);
  assign expire   = tick && at_lim;
  assign clr_req  = wr_stat && wdata[0];

  pscl_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctl_q.run),
    .restart (run_rise),
    .code    (ctl_q.code),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      lim_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_lim) lim_q <= wdata;
      if (wr_ctl)                     ctl_q     <= ctl_new;
      else if (expire && ctl_q.single) ctl_q.run <= 1'b0;
      if (run_rise)    cnt_q <= '0;
      else if (expire) cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_q + DATA_W'(1);
      if (expire)       pend_q <= 1'b1;
      else if (clr_req) pend_q <= 1'b0;
    end
  end

  assign ctl_rd  = ctl_encode(ctl_q);
  assign stat_rd = {{(DATA_W-1){1'b0}}, pend_q};
  assign lim_rd  = lim_q;
  assign cnt_rd  = cnt_q;
  assign irq_o   = pend_q && ctl_q.irq_en;

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr_ctl) |=> (cnt_q == '0 && pend_q));
  assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctl_q.single && !wr_ctl) |=> !ctl_q.run);
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_rise |=> (cnt_q == '0));
  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.run && !run_rise) |=> $stable(cnt_q));
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !pend_q);
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
  import pscl_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq
);
  localparam int SEL_W = ADDR_W - 7;

  logic [SEL_W-1:0]  ch_field;
  logic              in_win;
  logic [1:0]        reg_idx;
  logic              rd_en;
  logic [DATA_W-1:0] rd_mux;
  logic [NUM_CH-1:0] ch_irq;
  logic [DATA_W-1:0] ctl_rd  [NUM_CH];
  logic [DATA_W-1:0] stat_rd [NUM_CH];
  logic [DATA_W-1:0] lim_rd  [NUM_CH];
  logic [DATA_W-1:0] cnt_rd  [NUM_CH];

  assign ch_field = bus_addr[ADDR_W-1:7];
  assign in_win   = (bus_addr[6:4] == 3'd0) && (bus_addr[1:0] == 2'd0);
  assign reg_idx  = bus_addr[3:2];
  assign rd_en    = bus_sel && !bus_wr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = bus_sel && bus_wr && in_win && (ch_field == SEL_W'(c + 1));
    pscl_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctl  (hit && reg_idx == 2'd0),
      .wr_stat (hit && reg_idx == 2'd1),
      .wr_lim  (hit && reg_idx == 2'd2),
      .wdata   (bus_wdata),
      .ctl_rd  (ctl_rd[c]),
      .stat_rd (stat_rd[c]),
      .lim_rd  (lim_rd[c]),
      .cnt_rd  (cnt_rd[c]),
      .irq_o   (ch_irq[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (in_win && ch_field == SEL_W'(c + 1)) begin
        case (reg_idx)
          2'd0:    rd_mux = ctl_rd[c];
          2'd1:    rd_mux = stat_rd[c];
          2'd2:    rd_mux = lim_rd[c];
          default: rd_mux = cnt_rd[c];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

  assign irq = |ch_irq;

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(bus_rdata));
  assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_irq == '0) |-> !irq);
endmodule

// File: tb/pscl_timer_bench.sv
`timescale 1ns/100ps
module pscl_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic rd_pend = 1'b0;
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  pscl_timer u_pscl_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_pend <= bus_sel && !bus_wr;
  end

  // monitor: pops expected read values as the design returns them
  always @(negedge clk) begin
    if (rd_pend) begin
      n_chk++;
      if (q_exp.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected read data act=%h exp=none", bus_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  function automatic int eff(input int n);
    return (n > 8) ? 8 : n;
  endfunction
  function automatic int nticks(input int e, input int n);
    return e >> eff(n);
  endfunction
  function automatic logic [15:0] cnt_per(input int e, input int n, input int lim);
    return 16'(nticks(e, n) % (lim + 1));
  endfunction
  function automatic logic [15:0] cnt_one(input int e, input int n, input int lim);
    return (nticks(e, n) > lim) ? 16'd0 : 16'(nticks(e, n));
  endfunction
  function automatic logic [15:0] flag_of(input int e, input int n, input int lim);
    return (nticks(e, n) > lim) ? 16'd1 : 16'd0;
  endfunction
  function automatic logic [8:0] adr(input int ch, input int r);
    return 9'(32'h80 + 32'h80 * ch + 4 * r);
  endfunction

  task automatic wr(input int ch, input int r, input logic [15:0] v);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = adr(ch, r); bus_wdata = v;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int r, input logic [15:0] e, input string t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = adr(ch, r);
    q_exp.push_back(e); q_tag.push_back(t);
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic chk(input logic [15:0] a, input logic [15:0] e, input string t);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", t, a, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int w0, w1, d;
    logic [15:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R1 reset values
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 4; r++) rd(c, r, 16'h0, "R1 reset value");
    chk({15'd0, irq}, 16'd0, "R1 irq after reset");
    // R2 control readback, R1 count read-only
    wr(0, 0, 16'hFFDF);
    rd(0, 0, 16'h011F, "R2 control readback");
    wr(0, 3, 16'h1234);
    rd(0, 3, 16'h0000, "R1 count ignores writes");
    wr(0, 0, 16'h0000);
    // R11 one-cycle read, data holds
    wr(0, 2, 16'hABCD);
    rd(0, 2, 16'hABCD, "R11 read latency");
    idle(3);
    chk(bus_rdata, 16'hABCD, "R11 rdata holds");
    // R3/R5 divide by 1, periodic
    wr(0, 2, 16'd10);
    wr(0, 0, 16'h0020); w0 = cyc;
    for (int k = 0; k < 3; k++) rd(0, 3, cnt_per(cyc - w0, 0, 10), "R3 count div1");
    idle(8);
    rd(0, 3, cnt_per(cyc - w0, 0, 10), "R5 count wraps at limit");
    rd(0, 1, flag_of(cyc - w0, 0, 10), "R5 flag set");
    chk({15'd0, irq}, 16'd0, "R10 irq masked");
    // R13 hold while disabled
    wr(0, 0, 16'h0000); d = cyc;
    held = cnt_per(d - w0, 0, 10);
    idle(5);
    rd(0, 3, held, "R13 count holds");
    // R9 write-1-to-clear
    wr(0, 1, 16'h0000);
    rd(0, 1, 16'h0001, "R9 write 0 keeps flag");
    wr(0, 1, 16'h0001);
    rd(0, 1, 16'h0000, "R9 write 1 clears");
    // R8 restart with new limit
    wr(0, 2, 16'd7);
    wr(0, 0, 16'h0020); w0 = cyc;
    rd(0, 3, cnt_per(cyc - w0, 0, 7), "R8 count cleared on enable");
    idle(10);
    rd(0, 1, flag_of(cyc - w0, 0, 7), "R8 new limit used");
    wr(0, 0, 16'h0000); wr(0, 1, 16'h0001);
    // R3 divide by 8
    wr(0, 2, 16'd20);
    wr(0, 0, 16'h0023); w0 = cyc;
    idle(30);
    rd(0, 3, cnt_per(cyc - w0, 3, 20), "R3 div8 count");
    idle(13);
    rd(0, 3, cnt_per(cyc - w0, 3, 20), "R3 div8 count later");
    wr(0, 0, 16'h0000); wr(0, 1, 16'h0001);
    // R4 code 12 behaves as 8
    wr(0, 2, 16'd3);
    wr(0, 0, 16'h002C); w0 = cyc;
    idle(600);
    rd(0, 3, cnt_per(cyc - w0, 12, 3), "R4 clamp count");
    rd(0, 0, 16'h002C, "R4 code readback");
    wr(0, 0, 16'h0000); wr(0, 1, 16'h0001);
    // R7/R10 single shot on channel 1
    wr(1, 2, 16'd5);
    wr(1, 0, 16'h0132); w1 = cyc;
    idle(6);
    rd(1, 3, cnt_one(cyc - w1, 2, 5), "R7 count before expiry");
    chk({15'd0, irq}, 16'd0, "R10 irq idle");
    idle(30);
    rd(1, 3, 16'h0000, "R7 count back to 0");
    rd(1, 0, 16'h0112, "R7 run dropped");
    rd(1, 1, 16'h0001, "R7 flag set");
    chk({15'd0, irq}, 16'd1, "R10 irq raised");
    idle(20);
    rd(1, 3, 16'h0000, "R7 count stays 0");
    wr(1, 0, 16'h0012);
    chk({15'd0, irq}, 16'd0, "R10 irq masked by enable bit");
    rd(1, 1, 16'h0001, "R10 flag kept while masked");
    wr(1, 1, 16'h0001);
    rd(1, 1, 16'h0000, "R9 clear channel 1");
    // R6/R12 free-running and independent channels
    wr(1, 2, 16'hFFFF);
    wr(1, 0, 16'h0020); w1 = cyc;
    wr(0, 2, 16'd50);
    wr(0, 0, 16'h0021); w0 = cyc;
    idle(65540);
    rd(1, 3, cnt_per(cyc - w1, 0, 65535), "R6 free-running wrap");
    rd(1, 1, flag_of(cyc - w1, 0, 65535), "R6 flag at wrap");
    rd(0, 3, cnt_per(cyc - w0, 1, 50), "R12 channel 0 independent");
    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule